// File: doc/BRIEF.md
# Ternary Match Forwarding Lookup

This block is a small ternary content-addressable lookup engine for a packet forwarding path. It holds a table of entries. Each entry has a stored value, a care mask and a valid flag. A key presented on the lookup port is compared against every entry at once. A bit whose care flag is clear matches any key bit. A bit whose care flag is set must equal the key bit.

When several entries match, the one with the smallest index wins. Software that writes more specific prefixes at lower indices therefore gets longest-prefix matching, and an all-wildcard entry at the last index acts as a default route. The winning index addresses a second memory that holds the forwarding word. The response carries a hit flag, the index and that word.

Lookups are pipelined. The compare and the priority selection take one stage, and the associated-data read takes the second. A new key can be accepted every cycle. Table entries and associated-data words are loaded through two separate write ports.

Top module: `tcam_fwd_lookup`

## Requirements
- R1: An entry bit with care flag 0 matches either key bit value; an entry bit with care flag 1 matches only when the key bit equals the stored bit, and an entry matches only when all its bits match.
- R2: An entry whose valid flag is 0 never matches, whatever its value and care mask; after reset every entry is invalid.
- R3: When more than one valid entry matches, the response index is the smallest matching index.
- R4: A lookup that matches no entry responds with rsp_hit = 0, rsp_index = 0 and rsp_data = 0.
- R5: On a hit, rsp_data equals the associated-data word last written at the winning index.
- R6: A request accepted at a rising edge (lk_req = 1) produces rsp_valid = 1 exactly two rising edges later; requests on consecutive cycles give responses on consecutive cycles, in order.
- R7: An entry write (ent_we = 1) is seen by lookups requested in the following cycle or later; a lookup requested in the same cycle as the write uses the previous contents.
- R8: While rst is high and in the cycle after it, rsp_valid and rsp_hit are 0.
- R9: rsp_hit is 1 only together with rsp_valid = 1; with no request two cycles earlier, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ent_we | input | 1 | Write one table entry |
| ent_idx | input | IDX_W | Entry index to write |
| ent_value | input | KEY_W | Stored bit values |
| ent_care | input | KEY_W | Care mask, 1 = compare this bit |
| ent_valid | input | 1 | Valid flag written with the entry |
| ad_we | input | 1 | Write one associated-data word |
| ad_idx | input | IDX_W | Associated-data address |
| ad_data | input | DATA_W | Forwarding word to store |
| lk_req | input | 1 | Lookup request, accepted every cycle |
| lk_key | input | KEY_W | Key to look up |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some valid entry matched |
| rsp_index | output | IDX_W | Winning entry index, 0 on miss |
| rsp_data | output | DATA_W | Forwarding word, 0 on miss |

## Verification
The table is loaded with exact entries, prefix entries with trailing wildcards, entries with wildcards in the middle, and a catch-all at the last index. Keys are chosen so that each shape wins at least once. Some keys match both a long and a short prefix, which shows that the lowest index wins. One key matches only the catch-all, which shows the default route. These keys are issued back to back, so the same walk also checks the latency and the order of the responses. Directed cases cover the following: a lookup on an empty table; a write and a lookup in the same cycle, then a lookup in the next cycle; a catch-all entry that is invalidated and so turns a hit into a miss; and idle cycles with no request.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned TCAM_DEPTH_DEF  = 8;
  localparam int unsigned TCAM_KEY_W_DEF  = 6;
  localparam int unsigned TCAM_DATA_W_DEF = 16;

  // per-stage control flags carried down the lookup pipeline
  typedef struct packed {
    logic valid;
    logic hit;
  } stage_flags_t;
endpackage

// File: rtl/tcam_entry_array.sv
module tcam_entry_array #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned KEY_W = 6,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [KEY_W-1:0] wvalue,
  input  logic [KEY_W-1:0] wcare,
  input  logic             wvalid,
  input  logic [KEY_W-1:0] key,
  output logic [DEPTH-1:0] match
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [KEY_W-1:0] value_q;
    logic [KEY_W-1:0] care_q;
    logic             valid_q;
    logic             sel;

    assign sel = we && (widx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
      end else if (sel) begin
        valid_q <= wvalid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        value_q <= wvalue;
        care_q  <= wcare;
      end
    end

    // a bit disagrees only where care is set and the bits differ
    assign match[e] = valid_q && (((key ^ value_q) & care_q) == '0);
  end
endmodule

// File: rtl/tcam_prio_sel.sv
module tcam_prio_sel #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic [DEPTH-1:0] grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // unary stage: bit k survives only if no lower bit is set
  always_comb begin
    logic seen;
    seen  = 1'b0;
    grant = '0;
    for (int k = 0; k < DEPTH; k++) begin
      grant[k] = req[k] & ~seen;
      seen     = seen | req[k];
    end
    any = seen;
  end

  // binary stage: OR together the index of the single granted bit
  always_comb begin
    idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (grant[k]) begin
        idx = idx | IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/tcam_assoc_ram.sv
module tcam_assoc_ram #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/tcam_fwd_lookup.sv
module tcam_fwd_lookup #(
  parameter int unsigned DEPTH  = tcam_pkg::TCAM_DEPTH_DEF,
  parameter int unsigned KEY_W  = tcam_pkg::TCAM_KEY_W_DEF,
  parameter int unsigned DATA_W = tcam_pkg::TCAM_DATA_W_DEF,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [KEY_W-1:0]  ent_value,
  input  logic [KEY_W-1:0]  ent_care,
  input  logic              ent_valid,
  input  logic              ad_we,
  input  logic [IDX_W-1:0]  ad_idx,
  input  logic [DATA_W-1:0] ad_data,
  input  logic              lk_req,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [DATA_W-1:0] rsp_data
);
  import tcam_pkg::*;

  logic [DEPTH-1:0]  match_vec;
  logic [DEPTH-1:0]  grant_vec;
  logic              any_match;
  logic [IDX_W-1:0]  win_idx;
  logic [DATA_W-1:0] ram_rdata;

  stage_flags_t      s1_q, s2_q;
  logic [IDX_W-1:0]  s1_idx_q, s2_idx_q;

  tcam_entry_array #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_array (
    .clk    (clk),
    .rst    (rst),
    .we     (ent_we),
    .widx   (ent_idx),
    .wvalue (ent_value),
    .wcare  (ent_care),
    .wvalid (ent_valid),
    .key    (lk_key),
    .match  (match_vec)
  );

  tcam_prio_sel #(.DEPTH(DEPTH)) u_prio (
    .req   (match_vec),
    .grant (grant_vec),
    .any   (any_match),
    .idx   (win_idx)
  );

  // stage 1: compare and priority result
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      s1_idx_q <= '0;
    end else begin
      s1_q.valid <= lk_req;
      s1_q.hit   <= lk_req && any_match;
      s1_idx_q   <= (lk_req && any_match) ? win_idx : '0;
    end
  end

  tcam_assoc_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ad_we),
    .waddr (ad_idx),
    .wdata (ad_data),
    .re    (s1_q.valid),
    .raddr (s1_idx_q),
    .rdata (ram_rdata)
  );

  // stage 2: flags aligned with the memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_q     <= '0;
      s2_idx_q <= '0;
    end else begin
      s2_q     <= s1_q;
      s2_idx_q <= s1_idx_q;
    end
  end

  assign rsp_valid = s2_q.valid;
  assign rsp_hit   = s2_q.hit;
  assign rsp_index = s2_idx_q;
  assign rsp_data  = s2_q.hit ? ram_rdata : '0;
endmodule

// File: rtl/tcam_fwd_lookup_chk.sv
module tcam_fwd_lookup_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_index,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DEPTH-1:0]  match_vec,
  input logic [DEPTH-1:0]  grant_vec
);
  AST_GRANT_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec)); // R3
  AST_GRANT_WITHIN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & ~match_vec) == '0); // R3
  AST_GRANT_WHEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (match_vec != '0) |-> (grant_vec != '0)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_index == '0 && rsp_data == '0)); // R4
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> ##2 rsp_valid); // R6
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_req, 2)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_hit)); // R8
endmodule

bind tcam_fwd_lookup tcam_fwd_lookup_chk #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_req    (lk_req),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_index (rsp_index),
  .rsp_data  (rsp_data),
  .match_vec (match_vec),
  .grant_vec (grant_vec)
);

// File: tb/tcam_fwd_lookup_test.sv
module tcam_fwd_lookup_test;
  localparam int DEPTH = 8, KEY_W = 6, DATA_W = 16, IDX_W = 3, NV = 8;

  // vector fields: {key[5:0], expected hit, expected index[2:0]}
  localparam logic [9:0] VEC [NV] = '{
    {6'b010110, 1'b1, 3'd0},   // exact entry
    {6'b101100, 1'b1, 3'd1},   // matches 1 and 2, lowest wins
    {6'b101001, 1'b1, 3'd2},   // short prefix
    {6'b110111, 1'b1, 3'd3},
    {6'b001011, 1'b1, 3'd4},
    {6'b000100, 1'b1, 3'd5},   // inner wildcards
    {6'b100110, 1'b1, 3'd6},   // matches 6 and 7
    {6'b110001, 1'b1, 3'd7}    // only the catch-all
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              ent_we = 1'b0, ent_valid = 1'b0;
  logic [IDX_W-1:0]  ent_idx = '0;
  logic [KEY_W-1:0]  ent_value = '0, ent_care = '0;
  logic              ad_we = 1'b0;
  logic [IDX_W-1:0]  ad_idx = '0;
  logic [DATA_W-1:0] ad_data = '0;
  logic              lk_req = 1'b0;
  logic [KEY_W-1:0]  lk_key = '0;
  logic              rsp_valid, rsp_hit;
  logic [IDX_W-1:0]  rsp_index;
  logic [DATA_W-1:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  tcam_fwd_lookup uut (
    .clk(clk), .rst(rst),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_value(ent_value),
    .ent_care(ent_care), .ent_valid(ent_valid),
    .ad_we(ad_we), .ad_idx(ad_idx), .ad_data(ad_data),
    .lk_req(lk_req), .lk_key(lk_key),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  function automatic logic [DATA_W-1:0] ad_word(int i);
    return 16'hF000 | (16'(i) * 16'h0101);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rsp(string req, logic hit, logic [IDX_W-1:0] idx);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"},   32'(rsp_hit),   32'(hit));
    chk({req, " index"}, 32'(rsp_index), hit ? 32'(idx) : 32'd0);
    chk({req, " data"},  32'(rsp_data),  hit ? 32'(ad_word(int'(idx))) : 32'd0);
  endtask

  task automatic wr_entry(int i, logic [KEY_W-1:0] v, logic [KEY_W-1:0] c, logic vld);
    ent_we = 1'b1; ent_idx = IDX_W'(i); ent_value = v; ent_care = c; ent_valid = vld;
    @(negedge clk);
    ent_we = 1'b0;
  endtask

  task automatic single(string req, logic [KEY_W-1:0] key, logic hit, logic [IDX_W-1:0] idx);
    lk_req = 1'b1; lk_key = key;
    @(negedge clk);
    lk_req = 1'b0;
    @(negedge clk);
    chk_rsp(req, hit, idx);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", 32'(rsp_valid), 32'd0);
    chk("R8 hit in reset", 32'(rsp_hit), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 valid after reset", 32'(rsp_valid), 32'd0);

    // empty table: every entry invalid, so a miss with zero data
    single("R2 R4 empty table", 6'b000000, 1'b0, 3'd0);

    // load the table: care bit 1 = compare, 0 = wildcard
    wr_entry(0, 6'b010110, 6'b111111, 1'b1);
    wr_entry(1, 6'b101100, 6'b111100, 1'b1);
    wr_entry(2, 6'b101000, 6'b111000, 1'b1);
    wr_entry(3, 6'b110100, 6'b111100, 1'b1);
    wr_entry(4, 6'b001000, 6'b111100, 1'b1);
    wr_entry(5, 6'b000000, 6'b011011, 1'b1);
    wr_entry(6, 6'b000010, 6'b011011, 1'b1);
    wr_entry(7, 6'b000000, 6'b000000, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      ad_we = 1'b1; ad_idx = IDX_W'(i); ad_data = ad_word(i);
      @(negedge clk);
    end
    ad_we = 1'b0;

    // back-to-back walk: response of request j-2 is checked at step j
    for (int j = 0; j < NV + 2; j++) begin
      if (j == 1) chk("R6 no early response", 32'(rsp_valid), 32'd0);
      if (j >= 2) chk_rsp("R1 R3 R5 R6 table walk", VEC[j-2][3], VEC[j-2][2:0]);
      if (j < NV) begin
        lk_req = 1'b1; lk_key = VEC[j][9:4];
      end else begin
        lk_req = 1'b0;
      end
      @(negedge clk);
    end

    // idle: no request two cycles earlier
    chk("R9 idle valid", 32'(rsp_valid), 32'd0);
    chk("R9 idle hit", 32'(rsp_hit), 32'd0);

    // write and lookup in the same cycle, then lookup in the next
    ent_we = 1'b1; ent_idx = 3'd0; ent_value = 6'b111111; ent_care = 6'b111111; ent_valid = 1'b1;
    lk_req = 1'b1; lk_key = 6'b111111;
    @(negedge clk);
    ent_we = 1'b0;
    @(negedge clk);
    lk_req = 1'b0;
    chk_rsp("R7 same-cycle write uses old table", 1'b1, 3'd7);
    @(negedge clk);
    chk_rsp("R7 next-cycle lookup sees write", 1'b1, 3'd0);

    // invalidate the catch-all: a key that only it matched now misses
    wr_entry(7, 6'b000000, 6'b000000, 1'b0);
    single("R2 R4 invalid catch-all", 6'b110001, 1'b0, 3'd0);
    single("R3 after invalidation", 6'b100000, 1'b1, 3'd5);

    report();
  end
endmodule